// File: doc/BRIEF.md
# Vector Whole-Register Group Move

This unit carries out a whole-register vector move. One 32-bit instruction word names a source register group and a destination register group. A 5-bit immediate in the word sets the group size. The unit checks that the group size and both register numbers are legal. If they are, it copies the source group into the destination group, one architectural register per clock cycle, lowest register first. The vector register file sits outside the unit. The unit drives two combinational read addresses into it, one for the source and one for the old destination, and one full-width write port.

The copy works element by element. The element width is taken as an input and selects 8, 16, 32 or 64 bits. A start index is also taken as an input. Elements below that start index keep their old destination value, so the unit reads the old destination register and merges it byte by byte before writing it back. Masking plays no part. When the move finishes, the unit reports it with a one-cycle done pulse. That pulse carries either an illegal flag or a request to clear the start index to zero.

Top module: `vwrmov_unit`

## Requirements
- R1: The source group base is taken from instruction bits [24:20], the destination group base from bits [11:7], and the group size from bits [19:15] plus one. All other instruction bits are ignored.
- R2: A group size other than 1, 2, 4 or 8 ends the operation one cycle after start. It raises `done` and `illegal`, makes no register write and leaves `vstart_clr` low.
- R3: A destination or source base that is not a multiple of the group size is treated as illegal, with the same outcome as R2.
- R4: A legal move writes destination base+k for k = 0 up to size-1, one register per cycle in ascending order, reading source base+k in the same cycle. No other register is written.
- R5: Inside a written register, every element whose group-wide index is below the captured start index keeps its old bytes, and every other element takes the source bytes. `sew_sel` codes 0, 1, 2 and 3 mean elements of 1, 2, 4 and 8 bytes.
- R6: When the start index is greater than or equal to the element count (size × VLEN / element width), the unit writes nothing and ends one cycle after start with `done` and `vstart_clr` high.
- R7: A successful move raises `done` together with `vstart_clr`, with `illegal` low, for one cycle, in the cycle right after the last write. The latency from the start edge is size+1 cycles.
- R8: While `busy` is high, `start` is ignored, and so are changes to `instr`, `vstart` and `sew_sel`. The operation in flight uses the values captured at its start.
- R9: After reset, `busy`, `done`, `illegal`, `vstart_clr` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a move with the present inputs (taken only when not busy) |
| instr | input | 32 | Instruction word holding the register fields and the group-size immediate |
| vstart | input | VSTART_W | Start element index |
| sew_sel | input | 2 | Element width code: 0=8, 1=16, 2=32, 3=64 bits |
| busy | output | 1 | A move is writing registers |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Valid with done: the instruction was rejected |
| vstart_clr | output | 1 | Valid with done: the start index must be cleared to zero |
| src_addr | output | 5 | Register file read address for the source register |
| src_data | input | VLEN | Register file read data at src_addr |
| dst_addr | output | 5 | Register file read address for the old destination; also the write address |
| dst_data | input | VLEN | Register file read data at dst_addr |
| wr_en | output | 1 | Write the merged data to dst_addr at the next rising edge |
| wr_data | output | VLEN | Merged register value |

## Verification
Some properties are checked by assertions on every cycle. `done` never arrives while `busy` is high. The illegal and clear flags appear only together with `done`, and never both at once. A rejected operation never follows a write. Consecutive writes step the destination address up by one. The per-byte merge selection never turns from "take source" back to "keep old" as the byte index rises, and with a zero start index the written data equals the source. Other behaviour shows only in the bench's scenarios: the exact register contents after moves with different sizes, element widths and start indices, the boundary where the start index equals the element count, rejection of misaligned groups, and a start pulse ignored in the middle of a move.

// File: rtl/vwrmov_pkg.sv
package vwrmov_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mov_state_e;

    localparam int REG_W = 5;

endpackage

// File: rtl/vwrmov_decode.sv
module vwrmov_decode
    import vwrmov_pkg::*;
(
    input  logic [REG_W-1:0] src_fld,
    input  logic [REG_W-1:0] dst_fld,
    input  logic [4:0]       size_fld,
    output logic [2:0]       grp_m1,
    output logic [3:0]       grp_size,
    output logic             legal
);

    logic size_ok;
    logic align_ok;

    always_comb begin
        grp_m1   = size_fld[2:0];
        grp_size = {1'b0, size_fld[2:0]} + 4'd1;
        // group size must be a power of two no larger than eight
        size_ok  = (size_fld[4:3] == 2'b00) &&
                   ((size_fld[2:0] == 3'd0) || (size_fld[2:0] == 3'd1) ||
                    (size_fld[2:0] == 3'd3) || (size_fld[2:0] == 3'd7));
        // bases aligned to the group size
        align_ok = ((src_fld[2:0] & size_fld[2:0]) == 3'd0) &&
                   ((dst_fld[2:0] & size_fld[2:0]) == 3'd0);
        legal    = size_ok && align_ok;
    end

    always_comb begin
        assert_legal_pow2_R2: assert (!legal || $onehot(grp_size));
    end

endmodule

// File: rtl/vwrmov_bytemask.sv
module vwrmov_bytemask #(
    parameter int VLEN     = 128,
    parameter int VSTART_W = 16
) (
    input  logic [2:0]          reg_k,
    input  logic [1:0]          sew_sel,
    input  logic [VSTART_W-1:0] vstart,
    output logic [VLEN/8-1:0]   take_src
);

    localparam int VLENB  = VLEN / 8;
    localparam int BOFF_W = $clog2(VLENB);
    localparam int IDX_W  = BOFF_W + 3;

    for (genvar b = 0; b < VLENB; b++) begin : g_byte
        logic [IDX_W-1:0] byte_idx;
        logic [IDX_W-1:0] elem_idx;
        assign byte_idx    = {reg_k, BOFF_W'(b)};
        assign elem_idx    = byte_idx >> sew_sel;
        assign take_src[b] = ({{(VSTART_W-IDX_W){1'b0}}, elem_idx} >= vstart);

        if (b > 0) begin : g_mono
            always_comb begin
                assert_take_monotone_R5: assert (!take_src[b-1] || take_src[b]);
            end
        end
    end

endmodule

// File: rtl/vwrmov_unit.sv
module vwrmov_unit
    import vwrmov_pkg::*;
#(
    parameter int VLEN     = 128,
    parameter int VSTART_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [31:0]         instr,
    input  logic [VSTART_W-1:0] vstart,
    input  logic [1:0]          sew_sel,
    output logic                busy,
    output logic                done,
    output logic                illegal,
    output logic                vstart_clr,
    output logic [REG_W-1:0]    src_addr,
    input  logic [VLEN-1:0]     src_data,
    output logic [REG_W-1:0]    dst_addr,
    input  logic [VLEN-1:0]     dst_data,
    output logic                wr_en,
    output logic [VLEN-1:0]     wr_data
);

    localparam int VLENB  = VLEN / 8;
    localparam int BOFF_W = $clog2(VLENB);
    localparam int CNT_W  = BOFF_W + 4;

    typedef struct packed {
        mov_state_e          st;
        logic [REG_W-1:0]    src_base;
        logic [REG_W-1:0]    dst_base;
        logic [2:0]          k;
        logic [2:0]          k_last;
        logic [1:0]          sew;
        logic [VSTART_W-1:0] vst;
        logic                done;
        logic                ill;
        logic                clr;
    } mov_regs_t;

    mov_regs_t r_d, r_q;

    // decode
    logic [2:0] grp_m1;
    logic [3:0] grp_size;
    logic       legal;
    logic       unused_instr_bits;

    assign unused_instr_bits = ^{instr[31:25], instr[14:12], instr[6:0]};

    vwrmov_decode u_dec (
        .src_fld  (instr[24:20]),
        .dst_fld  (instr[11:7]),
        .size_fld (instr[19:15]),
        .grp_m1   (grp_m1),
        .grp_size (grp_size),
        .legal    (legal)
    );

    // element count of the whole group at the requested width
    logic [CNT_W-1:0] elem_cnt;
    logic             past_end;

    always_comb begin
        elem_cnt = {grp_size, {BOFF_W{1'b0}}} >> sew_sel;
        past_end = vstart >= {{(VSTART_W-CNT_W){1'b0}}, elem_cnt};
    end

    // per-byte merge selection for the register being written
    logic [VLENB-1:0] take_src;

    vwrmov_bytemask #(
        .VLEN     (VLEN),
        .VSTART_W (VSTART_W)
    ) u_mask (
        .reg_k    (r_q.k),
        .sew_sel  (r_q.sew),
        .vstart   (r_q.vst),
        .take_src (take_src)
    );

    for (genvar b = 0; b < VLENB; b++) begin : g_merge
        assign wr_data[8*b +: 8] = take_src[b] ? src_data[8*b +: 8] : dst_data[8*b +: 8];
    end

    // next-state logic
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.ill  = 1'b0;
        r_d.clr  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (!legal) begin
                        r_d.done = 1'b1;
                        r_d.ill  = 1'b1;
                    end else if (past_end) begin
                        r_d.done = 1'b1;
                        r_d.clr  = 1'b1;
                    end else begin
                        r_d.st       = ST_RUN;
                        r_d.src_base = instr[24:20];
                        r_d.dst_base = instr[11:7];
                        r_d.k        = 3'd0;
                        r_d.k_last   = grp_m1;
                        r_d.sew      = sew_sel;
                        r_d.vst      = vstart;
                    end
                end
            end
            ST_RUN: begin
                if (r_q.k == r_q.k_last) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.clr  = 1'b1;
                end else begin
                    r_d.k = r_q.k + 3'd1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // outputs
    assign busy       = (r_q.st == ST_RUN);
    assign wr_en      = busy;
    assign src_addr   = r_q.src_base | {2'b00, r_q.k};
    assign dst_addr   = r_q.dst_base | {2'b00, r_q.k};
    assign done       = r_q.done;
    assign illegal    = r_q.ill;
    assign vstart_clr = r_q.clr;

    // assertions
    assert_flags_need_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal || vstart_clr) |-> done);

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vstart_clr |-> !illegal);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_illegal_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> !$past(wr_en));

    assert_write_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (dst_addr == $past(dst_addr) + 5'd1));

    assert_zero_start_copies_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (r_q.vst == '0)) |-> (wr_data == src_data));

endmodule

// File: tb/vwrmov_unit_test.sv
module vwrmov_unit_test;

    localparam int VLEN     = 128;
    localparam int VLENB    = VLEN / 8;
    localparam int NREG     = 32;
    localparam int VSTART_W = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [31:0]         instr = '0;
    logic [VSTART_W-1:0] vstart = '0;
    logic [1:0]          sew_sel = '0;
    logic                busy, done, illegal, vstart_clr, wr_en;
    logic [4:0]          src_addr, dst_addr;
    logic [VLEN-1:0]     src_data, dst_data, wr_data;

    always #5 clk = ~clk;

    vwrmov_unit #(.VLEN(VLEN), .VSTART_W(VSTART_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .vstart(vstart), .sew_sel(sew_sel), .busy(busy), .done(done),
        .illegal(illegal), .vstart_clr(vstart_clr),
        .src_addr(src_addr), .src_data(src_data),
        .dst_addr(dst_addr), .dst_data(dst_data),
        .wr_en(wr_en), .wr_data(wr_data)
    );

    // register file model around the unit
    logic [VLEN-1:0] rf  [NREG];
    logic [VLEN-1:0] mdl [NREG];
    logic            load = 1'b1;

    function automatic logic [VLEN-1:0] init_val(int r);
        logic [VLEN-1:0] v;
        for (int b = 0; b < VLENB; b++) v[8*b +: 8] = 8'(r * 37 + b * 11 + 1);
        return v;
    endfunction

    assign src_data = rf[src_addr];
    assign dst_data = rf[dst_addr];

    always @(posedge clk) begin
        if (load) begin
            for (int r = 0; r < NREG; r++) rf[r] <= init_val(r);
        end else if (wr_en) begin
            rf[dst_addr] <= wr_data;
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    typedef struct {
        bit                   ill;
        bit                   clr;
        int                   lat;
        int                   start_cyc;
        logic [NREG*VLEN-1:0] img;
        string                tag;
    } item_t;

    item_t sb_q[$];

    function automatic logic [31:0] mk(logic [4:0] vs, logic [4:0] imm, logic [4:0] vdst);
        return {6'b100111, 1'b1, vs, imm, 3'b011, vdst, 7'b1010111};
    endfunction

    // monitor: compare each completion with the oldest expected item
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R8 done with no operation pending", 64'(done), 64'd0);
            end else begin
                item_t it;
                int bad;
                it = sb_q.pop_front();
                bad = -1;
                chk(illegal == it.ill, {it.tag, " illegal flag"}, 64'(illegal), 64'(it.ill));
                chk(vstart_clr == it.clr, {it.tag, " R7 vstart_clr flag"}, 64'(vstart_clr), 64'(it.clr));
                chk((cyc - it.start_cyc) == it.lat, {it.tag, " R7 latency"},
                    64'(cyc - it.start_cyc), 64'(it.lat));
                for (int r = NREG - 1; r >= 0; r--)
                    if (rf[r] != it.img[r*VLEN +: VLEN]) bad = r;
                if (bad < 0)
                    chk(1'b1, {it.tag, " R4 register file"}, 64'd0, 64'd0);
                else
                    chk(1'b0, $sformatf("%s R4 register file v%0d", it.tag, bad),
                        rf[bad][63:0], it.img[bad*VLEN +: 64]);
            end
        end
    end

    // driver: compute the expected result, queue it, issue the instruction
    task automatic run_op(input logic [4:0] vs, input logic [4:0] imm, input logic [4:0] vdst,
                          input int vst, input logic [1:0] sew, input bit intrude, input string tag);
        item_t it;
        int    gsz;
        bit    lgl;
        int    cnt;
        gsz = int'(imm) + 1;
        lgl = (gsz == 1 || gsz == 2 || gsz == 4 || gsz == 8) &&
              (int'(vs) % gsz == 0) && (int'(vdst) % gsz == 0);
        cnt = gsz * VLENB / (1 << sew);
        if (lgl && vst < cnt) begin
            for (int k = 0; k < gsz; k++)
                for (int b = 0; b < VLENB; b++)
                    if (((k * VLENB + b) >> sew) >= vst)
                        mdl[int'(vdst) + k][8*b +: 8] = mdl[int'(vs) + k][8*b +: 8];
        end
        it.ill = !lgl;
        it.clr = lgl;
        it.lat = (lgl && vst < cnt) ? gsz + 1 : 1;
        it.tag = tag;
        for (int r = 0; r < NREG; r++) it.img[r*VLEN +: VLEN] = mdl[r];
        @(negedge clk);
        it.start_cyc = cyc;
        sb_q.push_back(it);
        start   = 1'b1;
        instr   = mk(vs, imm, vdst);
        vstart  = VSTART_W'(vst);
        sew_sel = sew;
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            @(negedge clk);
            chk(busy == 1'b1, "R8 busy during move", 64'(busy), 64'd1);
            start   = 1'b1;
            instr   = mk(5'd0, 5'd2, 5'd0);
            vstart  = '0;
            sew_sel = 2'd3;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int r = 0; r < NREG; r++) mdl[r] = init_val(r);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk({busy, done, illegal, vstart_clr, wr_en} == 5'b0, "R9 outputs after reset",
            64'({busy, done, illegal, vstart_clr, wr_en}), 64'd0);

        run_op(5'd3,  5'd0, 5'd5,  0,  2'd0, 1'b0, "R1 R4 single register");
        run_op(5'd8,  5'd1, 5'd2,  0,  2'd2, 1'b0, "R1 R4 pair");
        run_op(5'd4,  5'd3, 5'd12, 5,  2'd1, 1'b0, "R5 quad sew16 start5");
        run_op(5'd16, 5'd7, 5'd0,  37, 2'd0, 1'b0, "R5 octet sew8 start37");
        run_op(5'd0,  5'd7, 5'd24, 9,  2'd3, 1'b0, "R5 octet sew64 start9");
        run_op(5'd20, 5'd0, 5'd21, 15, 2'd0, 1'b0, "R5 last element only");
        run_op(5'd6,  5'd0, 5'd6,  0,  2'd2, 1'b0, "R4 same source and destination");
        run_op(5'd0,  5'd2, 5'd4,  0,  2'd0, 1'b0, "R2 size three");
        run_op(5'd8,  5'd5, 5'd16, 0,  2'd0, 1'b0, "R2 size six");
        run_op(5'd0,  5'd31, 5'd0, 0,  2'd1, 1'b0, "R2 size thirtytwo");
        run_op(5'd0,  5'd1, 5'd3,  0,  2'd0, 1'b0, "R3 odd destination");
        run_op(5'd6,  5'd3, 5'd8,  0,  2'd0, 1'b0, "R3 misaligned source");
        run_op(5'd2,  5'd1, 5'd10, 4,  2'd3, 1'b0, "R6 start equals count");
        run_op(5'd1,  5'd0, 5'd9,  100, 2'd0, 1'b0, "R6 start beyond count");
        run_op(5'd24, 5'd7, 5'd8,  3,  2'd1, 1'b1, "R8 start while busy");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule